// File: doc/BRIEF.md
# Iterative GF(2) Polynomial Divider

This unit divides one unsigned binary polynomial by another, both held as WIDTH-bit vectors. Subtraction is a bitwise XOR and no carries propagate. It returns a WIDTH-bit quotient and a WIDTH-bit remainder. A caller puts the dividend and divisor on the inputs and pulses `start_i` while the unit is idle. The unit then holds `busy_o` high for a fixed number of cycles and pulses `done_o` once, with the results on the output registers.

Inside the loop, the working remainder and the divisor are each shifted toward the most significant bit on their own, and each has its own shift counter. On every step, the top bits of the two registers choose one of four actions:
- XOR the divisor into the remainder and set quotient bit 0.
- Shift only the divisor.
- Shift the remainder together with the quotient.
- Shift both the remainder and the divisor.

The datapath stops changing once the divisor is aligned, the remainder top bit is clear and the two counters are equal. The step counter still runs to a fixed limit. At the end, the remainder is shifted right by its counter to put it back in place. A zero divisor does not enter the loop. It is reported on a separate flag.

Top module: `gf2_divider`

## Requirements
- R1: For a nonzero divisor, `quotient_o` equals the quotient of GF(2) polynomial long division of the dividend by the divisor, where bit i is the coefficient of x^i and subtraction is XOR.
- R2: For a nonzero divisor, `remainder_o` has a lower degree than the divisor (no set bit at or above the divisor's highest set bit), and the carry-less product of quotient and divisor, XORed with the remainder, equals the dividend.
- R3: For a nonzero divisor, `busy_o` is high from the edge that accepts `start_i` until `done_o` rises. `done_o` rises on the (3*WIDTH-1)-th rising edge after the accepting edge, whatever the operand values.
- R4: `done_o` is high for exactly one cycle per accepted operation, and `busy_o` is low whenever `done_o` is high.
- R5: A zero divisor completes on the edge after the accepting edge, with `div_zero_o` = 1, `quotient_o` = 0 and `remainder_o` equal to the dividend. `busy_o` stays low.
- R6: A `start_i` that arrives while `busy_o` is high is ignored. The running operation finishes with its own operands and its own latency, and no extra `done_o` pulse appears.
- R7: `quotient_o` and `remainder_o` change only on the edge that raises `done_o`, and they hold their values until the next operation completes. `div_zero_o` is cleared when a nonzero-divisor start is accepted.
- R8: After an active-low reset, `busy_o`, `done_o`, `div_zero_o`, `quotient_o` and `remainder_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted only while idle |
| dividend_i | input | WIDTH | Dividend polynomial, sampled at the accepting edge |
| divisor_i | input | WIDTH | Divisor polynomial, sampled at the accepting edge |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quotient_o | output | WIDTH | Quotient polynomial |
| remainder_o | output | WIDTH | Remainder polynomial |
| div_zero_o | output | 1 | Last accepted divisor was zero |

## Verification
On every cycle, the bound checker checks the following:
- The completion pulse is one cycle wide and never overlaps busy.
- The latency is fixed, counted from the accepting edge.
- Zero-divisor completion happens on the next edge.
- Results do not move between completions.
- The datapath never leaves its settled state once it has reached it.
- The division identity and the remainder-degree bound hold on every result.

Only the bench's scenarios can show that the quotient matches an independent long division for every operand pair. The same goes for showing that a start request during a busy operation leaves its result and timing untouched, and that the reset values are correct.

// File: rtl/gf2_div_pkg.sv
package gf2_div_pkg;

  typedef enum logic [2:0] {
    K_HOLD,
    K_XOR,
    K_DSH,
    K_RSH,
    K_BOTH
  } step_kind_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_RUN,
    S_FIN
  } ctl_state_e;

  // Picks the action of one loop step from the two top bits and
  // whether the remainder shift count has caught up with the divisor's.
  function automatic step_kind_e pick_step(input logic r_top,
                                           input logic d_top,
                                           input logic counts_equal);
    if (d_top && !r_top && counts_equal) return K_HOLD;
    if (r_top && d_top)                  return K_XOR;
    if (r_top)                           return K_DSH;
    if (d_top)                           return K_RSH;
    return K_BOTH;
  endfunction

endpackage

// File: rtl/gf2_div_step.sv
module gf2_div_step
  import gf2_div_pkg::*;
#(
  parameter int W  = 8,
  parameter int CW = 3
) (
  input  logic [W-1:0]  r_q,
  input  logic [W-1:0]  d_q,
  input  logic [W-1:0]  q_q,
  input  logic [CW-1:0] rs_q,
  input  logic [CW-1:0] ds_q,
  output logic [W-1:0]  r_n,
  output logic [W-1:0]  d_n,
  output logic [W-1:0]  q_n,
  output logic [CW-1:0] rs_n,
  output logic [CW-1:0] ds_n,
  output step_kind_e    kind_o,
  output logic          settled_o
);

  always_comb begin
    r_n    = r_q;
    d_n    = d_q;
    q_n    = q_q;
    rs_n   = rs_q;
    ds_n   = ds_q;
    kind_o = pick_step(r_q[W-1], d_q[W-1], rs_q == ds_q);
    unique case (kind_o)
      K_XOR: begin
        r_n    = r_q ^ d_q;
        q_n[0] = 1'b1;
      end
      K_DSH: begin
        d_n  = d_q << 1;
        ds_n = ds_q + 1'b1;
      end
      K_RSH: begin
        r_n  = r_q << 1;
        q_n  = q_q << 1;
        rs_n = rs_q + 1'b1;
      end
      K_BOTH: begin
        r_n  = r_q << 1;
        d_n  = d_q << 1;
        rs_n = rs_q + 1'b1;
        ds_n = ds_q + 1'b1;
      end
      default: ;
    endcase
  end

  assign settled_o = (kind_o == K_HOLD);

endmodule

// File: rtl/gf2_div_ctrl.sv
module gf2_div_ctrl
  import gf2_div_pkg::*;
#(
  parameter int STEPS = 22,
  parameter int SCW   = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic divisor_zero_i,
  output logic accept_o,
  output logic zero_accept_o,
  output logic step_en_o,
  output logic finish_o,
  output logic busy_o
);

  ctl_state_e     state_q;
  logic [SCW-1:0] cnt_q;
  logic           last_step;

  assign accept_o      = (state_q == S_IDLE) && start_i && !divisor_zero_i;
  assign zero_accept_o = (state_q == S_IDLE) && start_i && divisor_zero_i;
  assign step_en_o     = (state_q == S_RUN);
  assign last_step     = step_en_o && (cnt_q == SCW'(STEPS - 1));
  assign finish_o      = (state_q == S_FIN);
  assign busy_o        = (state_q != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          cnt_q <= '0;
          if (accept_o) state_q <= S_RUN;
        end
        S_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (last_step) state_q <= S_FIN;
        end
        S_FIN:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/gf2_divider.sv
module gf2_divider
  import gf2_div_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] quotient_o,
  output logic [WIDTH-1:0] remainder_o,
  output logic             div_zero_o
);

  localparam int STEPS = 3 * WIDTH - 2;
  localparam int SCW   = $clog2(STEPS + 1);
  localparam int CW    = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  // Undo the normalising left shifts applied to the working remainder.
  function automatic logic [WIDTH-1:0] realign(input logic [WIDTH-1:0] r,
                                               input logic [CW-1:0]    sh);
    return r >> sh;
  endfunction

  logic [WIDTH-1:0] r_q, d_q, q_q;
  logic [CW-1:0]    rs_q, ds_q;
  logic [WIDTH-1:0] r_n, d_n, q_n;
  logic [CW-1:0]    rs_n, ds_n;
  step_kind_e       kind_w;
  logic             settled_w;
  logic             accept_w, zero_accept_w, step_en_w, finish_w;
  logic             divisor_zero_w;

  assign divisor_zero_w = (divisor_i == '0);

  gf2_div_ctrl #(.STEPS(STEPS), .SCW(SCW)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .divisor_zero_i (divisor_zero_w),
    .accept_o       (accept_w),
    .zero_accept_o  (zero_accept_w),
    .step_en_o      (step_en_w),
    .finish_o       (finish_w),
    .busy_o         (busy_o)
  );

  gf2_div_step #(.W(WIDTH), .CW(CW)) u_step (
    .r_q       (r_q),
    .d_q       (d_q),
    .q_q       (q_q),
    .rs_q      (rs_q),
    .ds_q      (ds_q),
    .r_n       (r_n),
    .d_n       (d_n),
    .q_n       (q_n),
    .rs_n      (rs_n),
    .ds_n      (ds_n),
    .kind_o    (kind_w),
    .settled_o (settled_w)
  );

  // Working registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_q  <= '0;
      d_q  <= '0;
      q_q  <= '0;
      rs_q <= '0;
      ds_q <= '0;
    end else if (accept_w) begin
      r_q  <= dividend_i;
      d_q  <= divisor_i;
      q_q  <= '0;
      rs_q <= '0;
      ds_q <= '0;
    end else if (step_en_w) begin
      r_q  <= r_n;
      d_q  <= d_n;
      q_q  <= q_n;
      rs_q <= rs_n;
      ds_q <= ds_n;
    end
  end

  // Result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quotient_o  <= '0;
      remainder_o <= '0;
      div_zero_o  <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (zero_accept_w) begin
        quotient_o  <= '0;
        remainder_o <= dividend_i;
        div_zero_o  <= 1'b1;
        done_o      <= 1'b1;
      end else if (accept_w) begin
        div_zero_o <= 1'b0;
      end else if (finish_w) begin
        quotient_o  <= q_q;
        remainder_o <= realign(r_q, rs_q);
        done_o      <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/gf2_divider_chk.sv
module gf2_divider_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [WIDTH-1:0] dividend_i,
  input logic [WIDTH-1:0] divisor_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [WIDTH-1:0] quotient_o,
  input logic [WIDTH-1:0] remainder_o,
  input logic             div_zero_o,
  input logic             accept_w,
  input logic             zero_accept_w,
  input logic             step_en_w,
  input logic             settled_w
);

  localparam int STEPS = 3 * WIDTH - 2;

  logic [15:0]      lat_cnt;
  logic [WIDTH-1:0] n_lat, d_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_cnt <= '0;
      n_lat   <= '0;
      d_lat   <= '0;
    end else begin
      if (accept_w) begin
        lat_cnt <= '0;
        n_lat   <= dividend_i;
        d_lat   <= divisor_i;
      end else if (lat_cnt != 16'hFFFF) begin
        lat_cnt <= lat_cnt + 16'd1;
      end
    end
  end

  function automatic logic identity_ok(input logic [WIDTH-1:0] q,
                                       input logic [WIDTH-1:0] d,
                                       input logic [WIDTH-1:0] r,
                                       input logic [WIDTH-1:0] n);
    logic [2*WIDTH-1:0] acc;
    acc = '0;
    for (int i = 0; i < WIDTH; i++)
      if (d[i]) acc = acc ^ ({{WIDTH{1'b0}}, q} << i);
    acc = acc ^ {{WIDTH{1'b0}}, r};
    return acc == {{WIDTH{1'b0}}, n};
  endfunction

  function automatic logic degree_ok(input logic [WIDTH-1:0] r,
                                     input logic [WIDTH-1:0] d);
    int hb;
    hb = 0;
    for (int i = 0; i < WIDTH; i++) if (d[i]) hb = i;
    return (r >> hb) == '0;
  endfunction

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !div_zero_o) |-> (lat_cnt == 16'(STEPS + 1)));

  p_zero_fast_r5: assert property (@(posedge clk) disable iff (!rst_n)
    zero_accept_w |=> (done_o && div_zero_o && quotient_o == '0));

  p_hold_results_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(quotient_o) && $stable(remainder_o)));

  p_ignore_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en_w && start_i) |=> busy_o);

  p_settle_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en_w && settled_w) |=> (!step_en_w || settled_w));

  p_identity_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !div_zero_o) |->
      (identity_ok(quotient_o, d_lat, remainder_o, n_lat) &&
       degree_ok(remainder_o, d_lat)));

endmodule

bind gf2_divider gf2_divider_chk #(.WIDTH(WIDTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .dividend_i    (dividend_i),
  .divisor_i     (divisor_i),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .quotient_o    (quotient_o),
  .remainder_o   (remainder_o),
  .div_zero_o    (div_zero_o),
  .accept_w      (accept_w),
  .zero_accept_w (zero_accept_w),
  .step_en_w     (step_en_w),
  .settled_w     (settled_w)
);

// File: tb/sim_gf2_divider.sv
module sim_gf2_divider;

  localparam int W     = 5;
  localparam int STEPS = 3 * W - 2;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i;
  logic [W-1:0] dividend_i, divisor_i;
  logic         busy_o, done_o, div_zero_o;
  logic [W-1:0] quotient_o, remainder_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  gf2_divider #(.WIDTH(W)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .dividend_i  (dividend_i),
    .divisor_i   (divisor_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .quotient_o  (quotient_o),
    .remainder_o (remainder_o),
    .div_zero_o  (div_zero_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int top_bit(input int v);
    int h;
    h = -1;
    for (int i = 0; i < 32; i++) if ((v >> i) & 1) h = i;
    return h;
  endfunction

  // Schoolbook polynomial long division over GF(2).
  task automatic ref_div(input int n, input int d, output int q, output int r);
    int hd;
    hd = top_bit(d);
    q = 0;
    r = n;
    for (int i = W - 1; i >= 0; i--)
      if (hd + i < W && ((r >> (hd + i)) & 1)) begin
        r = r ^ (d << i);
        q = q | (1 << i);
      end
  endtask

  function automatic int cl_mul(input int a, input int b);
    int acc;
    acc = 0;
    for (int i = 0; i < W; i++) if ((b >> i) & 1) acc = acc ^ (a << i);
    return acc;
  endfunction

  task automatic run_op(input int n, input int d);
    int lat, eq, er, q0, r0;
    @(negedge clk);
    dividend_i = W'(n);
    divisor_i  = W'(d);
    start_i    = 1'b1;
    @(posedge clk);
    lat = 1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == (d != 0), "R3 busy after accept", busy_o, d != 0);
    while (!done_o && lat < 100) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    if (d == 0) begin
      check(lat == 1, "R5 zero-divisor latency", lat, 1);
      check(div_zero_o == 1'b1, "R5 flag", div_zero_o, 1);
      check(quotient_o == 0 && remainder_o == W'(n), "R5 results",
            remainder_o, n);
    end else begin
      ref_div(n, d, eq, er);
      check(lat == STEPS + 2, "R3 latency", lat, STEPS + 2);
      check(!busy_o, "R4 busy low with done", busy_o, 0);
      check(div_zero_o == 1'b0, "R7 flag cleared", div_zero_o, 0);
      check(quotient_o == W'(eq), "R1 quotient", quotient_o, eq);
      check(remainder_o == W'(er), "R2 remainder", remainder_o, er);
      check((cl_mul(quotient_o, d) ^ remainder_o) == n, "R2 identity",
            cl_mul(quotient_o, d) ^ remainder_o, n);
      check(top_bit(remainder_o) < top_bit(d), "R2 degree",
            top_bit(remainder_o), top_bit(d));
    end
    q0 = quotient_o;
    r0 = remainder_o;
    @(posedge clk);
    @(negedge clk);
    check(!done_o, "R4 single-cycle done", done_o, 0);
    check(quotient_o == q0 && remainder_o == r0, "R7 results hold",
          remainder_o, r0);
  endtask

  initial begin
    #(20 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    int lat, eq, er, dones;
    rst_n      = 1'b0;
    start_i    = 1'b0;
    dividend_i = '0;
    divisor_i  = '0;
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && !div_zero_o && quotient_o == 0 &&
          remainder_o == 0, "R8 reset state", busy_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Exhaustive sweep over all operand pairs
    for (int n = 0; n < (1 << W); n++)
      for (int d = 0; d < (1 << W); d++)
        run_op(n, d);

    // R6: restart attempts while busy are ignored
    @(negedge clk);
    dividend_i = W'(27);
    divisor_i  = W'(5);
    start_i    = 1'b1;
    @(posedge clk);
    lat   = 1;
    dones = 0;
    @(negedge clk);
    dividend_i = W'(3);
    divisor_i  = W'(0);
    while (lat < STEPS + 6) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (done_o) begin
        dones++;
        ref_div(27, 5, eq, er);
        check(lat == STEPS + 2, "R6 latency unchanged", lat, STEPS + 2);
        check(quotient_o == W'(eq) && remainder_o == W'(er) && !div_zero_o,
              "R6 result of first operands", quotient_o, eq);
      end
      if (lat == STEPS + 1) start_i = 1'b0;
    end
    check(dones == 1, "R6 single done", dones, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule